// File: doc/BRIEF.md
# Link Ready Status Override Sequencer

This block sets the two ready bits that the receive side of a full-duplex cell link reports to its partner device over a serial status backchannel. One bit is control-ready and the other is data-ready. After reset the block forces both bits low. The partner therefore treats the fabric link as not yet alive.

Software turns on the receiver. It then waits for the sticky idle-seen flag, either by polling it or by taking an interrupt. The flag is set by the first idle frame that the frame parser reports while the receiver is enabled. Software then releases the override in one of two ways. It can clear the force bit, so that the outgoing bits follow the idle-seen flag. It can also leave the force bit set and write both manual ready bits high. Frame parsing, serialization of the status bits and the data path belong to neighbouring blocks.

All state sits behind a small register port. Writes take effect on the next clock edge. Reads are combinational on the address.

Top module: `link_ready_override`

## Requirements
- R1: A synchronous active-high reset gives these values. The override register (address 0) reads 0x01. The receive-control register (address 1), the status register (address 2) and the interrupt-enable register (address 3) read 0x00. `ready_out` is 2'b00 and `irq` is 0.
- R2: While the force bit (address 0, bit 0) is 1, `ready_out[1]` equals the manual control-ready bit (address 0, bit 7) and `ready_out[0]` equals the manual data-ready bit (address 0, bit 6). This holds whatever the state of the idle-seen flag.
- R3: An `idle_pulse` that arrives while receive-enable (address 1, bit 0) is 0 is ignored. The status register stays 0x00.
- R4: An `idle_pulse` that arrives while receive-enable is 1 sets the idle-seen flag (address 2, bit 0) at the next edge. The flag then holds until software clears it.
- R5: While the force bit is 0, both bits of `ready_out` equal the idle-seen flag.
- R6: Writing 1 to address 2 bit 0 clears the idle-seen flag, and writing 0 there has no effect. If a clear and an accepted `idle_pulse` fall in the same cycle, the flag is set.
- R7: `irq` is 1 exactly when both the idle-seen flag and the interrupt enable (address 3, bit 0) are 1.
- R8: Bits 5 to 1 of the override register, bits 7 to 1 of the other three registers and every unmapped address read as 0, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` (combinational) |
| idle_pulse | input | 1 | One-cycle pulse for each idle frame detected |
| irq | output | 1 | Idle-seen interrupt |
| ready_out | output | 2 | Outgoing status: [1] control-ready, [0] data-ready |

## Verification
The bench aims at these corner cases:
- An idle pulse while receive is disabled. A design that latches it would report the link alive before software asked it to.
- A write-one-to-clear in the same cycle as an accepted idle pulse. A design that let the clear win would lose a detection.
- A write of 0 to the status register. A design that cleared on any write would drop the flag.
- A flag that is set while the force bit still holds the outputs. A design that mixed in the flag too early would let the partner leave the not-ready state early.
- Writes of all ones to the override register. A design that stored the unmapped bits would show them on reads.

// File: rtl/link_ready_pkg.sv
package link_ready_pkg;
   localparam int ADDR_OVR    = 0;
   localparam int ADDR_RXCTL  = 1;
   localparam int ADDR_STAT   = 2;
   localparam int ADDR_IRQEN  = 3;
   localparam int BIT_FORCE   = 0;
   localparam int BIT_MAN_DAT = 6;
   localparam int BIT_MAN_CTL = 7;
   localparam int BIT_RXEN    = 0;
   localparam int BIT_IDLE    = 0;
   localparam int BIT_IRQEN   = 0;

   typedef struct packed {
      logic force_en;
      logic man_ctl;
      logic man_dat;
      logic rx_en;
      logic irq_en;
   } ctrl_t;
endpackage

// File: rtl/lro_ctrl_regs.sv
module lro_ctrl_regs
   import link_ready_pkg::*;
#(
   parameter int REG_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output ctrl_t             ctrl,
   output logic              clr_req
);
   logic hit_ovr, hit_rx, hit_stat, hit_irq;

   assign hit_ovr  = reg_wr && (reg_addr == ADDR_W'(ADDR_OVR));
   assign hit_rx   = reg_wr && (reg_addr == ADDR_W'(ADDR_RXCTL));
   assign hit_stat = reg_wr && (reg_addr == ADDR_W'(ADDR_STAT));
   assign hit_irq  = reg_wr && (reg_addr == ADDR_W'(ADDR_IRQEN));

   assign clr_req = hit_stat && reg_wdata[BIT_IDLE];

   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl.force_en <= 1'b1;
         ctrl.man_ctl  <= 1'b0;
         ctrl.man_dat  <= 1'b0;
         ctrl.rx_en    <= 1'b0;
         ctrl.irq_en   <= 1'b0;
      end else begin
         if (hit_ovr) begin
            ctrl.force_en <= reg_wdata[BIT_FORCE];
            ctrl.man_ctl  <= reg_wdata[BIT_MAN_CTL];
            ctrl.man_dat  <= reg_wdata[BIT_MAN_DAT];
         end
         if (hit_rx)  ctrl.rx_en  <= reg_wdata[BIT_RXEN];
         if (hit_irq) ctrl.irq_en <= reg_wdata[BIT_IRQEN];
      end
   end

   p_ovr_write_r2: assert property (@(posedge clk) disable iff (rst)
      hit_ovr |=> (ctrl.force_en == $past(reg_wdata[BIT_FORCE])) &&
                  (ctrl.man_ctl == $past(reg_wdata[BIT_MAN_CTL])));
   p_rx_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !hit_rx |=> $stable(ctrl.rx_en));
endmodule

// File: rtl/lro_idle_latch.sv
module lro_idle_latch (
   input  logic clk,
   input  logic rst,
   input  logic rx_en,
   input  logic idle_pulse,
   input  logic clr_req,
   output logic flag
);
   logic take;

   assign take = rx_en && idle_pulse;

   always_ff @(posedge clk) begin
      if (rst)          flag <= 1'b0;
      else if (take)    flag <= 1'b1;
      else if (clr_req) flag <= 1'b0;
   end

   p_set_r4: assert property (@(posedge clk) disable iff (rst)
      take |=> flag);
   p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (flag && !clr_req) |=> flag);
   p_ignore_r3: assert property (@(posedge clk) disable iff (rst)
      (!flag && !take) |=> !flag);
   p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
      (clr_req && !take) |=> !flag);
endmodule

// File: rtl/lro_ready_sel.sv
module lro_ready_sel #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       force_en,
   input  logic       man_ctl,
   input  logic       man_dat,
   input  logic       flag,
   output logic [1:0] ready
);
   logic [1:0] pick;

   always_comb begin
      if (force_en) pick = {man_ctl, man_dat};
      else          pick = {flag, flag};
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) ready <= 2'b00;
            else     ready <= pick;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst;
         assign ready = pick;
      end
   endgenerate
endmodule

// File: rtl/link_ready_override.sv
module link_ready_override
   import link_ready_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int ADDR_W  = 2,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              idle_pulse,
   output logic              irq,
   output logic [1:0]        ready_out
);
   generate
      if (REG_W < BIT_MAN_CTL + 1) begin : g_bad_w
         $error("REG_W must hold bit %0d", BIT_MAN_CTL);
      end
      if (ADDR_W < 2) begin : g_bad_a
         $error("ADDR_W must cover four registers");
      end
   endgenerate

   ctrl_t ctrl;
   logic  clr_req;
   logic  flag;

   lro_ctrl_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .ctrl(ctrl), .clr_req(clr_req));

   lro_idle_latch u_latch (
      .clk(clk), .rst(rst), .rx_en(ctrl.rx_en), .idle_pulse(idle_pulse),
      .clr_req(clr_req), .flag(flag));

   lro_ready_sel #(.OUT_REG(OUT_REG)) u_sel (
      .clk(clk), .rst(rst), .force_en(ctrl.force_en), .man_ctl(ctrl.man_ctl),
      .man_dat(ctrl.man_dat), .flag(flag), .ready(ready_out));

   assign irq = flag && ctrl.irq_en;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_OVR)) begin
         reg_rdata[BIT_FORCE]   = ctrl.force_en;
         reg_rdata[BIT_MAN_CTL] = ctrl.man_ctl;
         reg_rdata[BIT_MAN_DAT] = ctrl.man_dat;
      end else if (reg_addr == ADDR_W'(ADDR_RXCTL)) begin
         reg_rdata[BIT_RXEN] = ctrl.rx_en;
      end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
         reg_rdata[BIT_IDLE] = flag;
      end else if (reg_addr == ADDR_W'(ADDR_IRQEN)) begin
         reg_rdata[BIT_IRQEN] = ctrl.irq_en;
      end
   end

   p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
      !ctrl.irq_en |-> !irq);

   generate
      if (!OUT_REG) begin : g_chk
         p_forced_r2: assert property (@(posedge clk) disable iff (rst)
            (reg_wr && reg_addr == ADDR_W'(ADDR_OVR) && reg_wdata[BIT_FORCE])
            |=> ready_out == {$past(reg_wdata[BIT_MAN_CTL]), $past(reg_wdata[BIT_MAN_DAT])});
         p_release_r5: assert property (@(posedge clk) disable iff (rst)
            (!ctrl.force_en && flag) |-> ready_out == 2'b11);
      end
   endgenerate
endmodule

// File: tb/link_ready_override_test.sv
module link_ready_override_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       idle_pulse = 1'b0;
   logic       irq;
   logic [1:0] ready_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   link_ready_override uut (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .idle_pulse(idle_pulse),
      .irq(irq), .ready_out(ready_out));

   // behavioural reference
   bit m_frc = 1, m_ctl = 0, m_dat = 0, m_rx = 0, m_ie = 0, m_flag = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_frc <= 1; m_ctl <= 0; m_dat <= 0; m_rx <= 0; m_ie <= 0; m_flag <= 0;
      end else begin
         if (reg_wr && reg_addr == 0) begin
            m_frc <= reg_wdata[0]; m_ctl <= reg_wdata[7]; m_dat <= reg_wdata[6];
         end
         if (reg_wr && reg_addr == 1) m_rx <= reg_wdata[0];
         if (reg_wr && reg_addr == 3) m_ie <= reg_wdata[0];
         if (m_rx && idle_pulse) m_flag <= 1;
         else if (reg_wr && reg_addr == 2 && reg_wdata[0]) m_flag <= 0;
      end
   end

   function automatic logic [7:0] m_read(input logic [1:0] a);
      case (a)
         2'd0: return {m_ctl, m_dat, 5'b0, m_frc};
         2'd1: return {7'b0, m_rx};
         2'd2: return {7'b0, m_flag};
         default: return {7'b0, m_ie};
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (!rst && !done) begin
         check(m_frc ? "R2 ready" : "R5 ready", ready_out,
               m_frc ? {m_ctl, m_dat} : {m_flag, m_flag});
         check("R7 irq", irq, m_flag && m_ie);
         check(reg_addr == 0 ? "R8 read" : "R4 read", reg_rdata, m_read(reg_addr));
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0; reg_wdata = 0;
   endtask

   task automatic pulse(input bit also_clr);
      @(negedge clk);
      idle_pulse = 1;
      if (also_clr) begin reg_wr = 1; reg_addr = 2; reg_wdata = 8'h01; end
      @(negedge clk);
      idle_pulse = 0; reg_wr = 0; reg_wdata = 0;
   endtask

   task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int lf = 32'h1ACE;
      repeat (3) @(negedge clk);
      rst = 0;
      // R1 reset values
      rd("R1", 0, 8'h01); rd("R1", 1, 8'h00); rd("R1", 2, 8'h00); rd("R1", 3, 8'h00);
      check("R1 ready", ready_out, 0); check("R1 irq", irq, 0);
      // R2 manual bits under force
      wr(0, 8'h81); check("R2 ctl only", ready_out, 2'b10);
      wr(0, 8'h41); check("R2 dat only", ready_out, 2'b01);
      wr(0, 8'hC1); check("R2 both", ready_out, 2'b11);
      // R8 unmapped bits
      wr(0, 8'hFF); rd("R8 ovr", 0, 8'hC1);
      wr(1, 8'hFE); rd("R8 rx", 1, 8'h00);
      wr(0, 8'h01); check("R2 low", ready_out, 2'b00);
      // R3 ignored while rx disabled
      pulse(0); rd("R3 status", 2, 8'h00); check("R3 ready", ready_out, 0);
      // R4 accepted
      wr(1, 8'h01); pulse(0); rd("R4 status", 2, 8'h01);
      repeat (3) @(negedge clk); rd("R4 sticky", 2, 8'h01);
      check("R2 flag masked", ready_out, 2'b00);
      // R7 interrupt
      check("R7 disabled", irq, 0);
      wr(3, 8'h01); check("R7 enabled", irq, 1);
      // R5 release
      wr(0, 8'h00); check("R5 released", ready_out, 2'b11);
      // R6 write one to clear
      wr(2, 8'h00); rd("R6 zero write", 2, 8'h01);
      wr(2, 8'h01); rd("R6 cleared", 2, 8'h00);
      check("R5 dropped", ready_out, 2'b00); check("R7 dropped", irq, 0);
      pulse(1); rd("R6 set wins", 2, 8'h01);
      // mixed stimulus against the model
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         reg_wr = lf[3] & lf[7];
         reg_addr = lf[5:4];
         reg_wdata = lf[15:8];
         idle_pulse = lf[17] & lf[19];
      end
      @(negedge clk);
      reg_wr = 0; idle_pulse = 0;
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule